// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Controller

This block sits between the interrupt delivery fabric and a processor core. Each incoming request carries a vector, a delivery mode and a level/edge flag. Fixed and lowest-priority requests are collected in a bitmap of pending vectors, one bit per vector, with a companion bitmap that records the trigger type. Four unmaskable kinds have one single-entry latch each: system-management, non-maskable, init and startup. An external-controller request also has a single-entry latch. Each latch holds the vector it captured.

Every cycle the block chooses one candidate and presents it to the core, together with its kind and vector. The choice follows a fixed order of kinds. A regular vector is offered only when it outranks the highest vector in service and its priority class is above the task-priority class. The core pulses `ack` to take the presented interrupt. Software pulses `eoi` to retire the highest in-service vector.

Top module: `irq_accept`

## Requirements
- R1: After reset nothing is pending (`int_pending`=0, `int_kind`=0, `int_vector`=0), no vector is in service (`isr_any`=0), and `tpr_value` is 0.
- R2: A request with mode 0 (fixed) or 1 (lowest priority) sets the pending bit of its vector. When that bit was clear, the trigger bit of the vector takes `req_level`. When the bit was already set, the trigger bit keeps its value. `int_level` shows the trigger bit of the highest pending regular vector.
- R3: A request with mode 2 (system-management), 4 (non-maskable), 5 (init), 6 (startup) or 7 (external) is latched with its vector only when no request of that kind is pending. A second one of the same kind is dropped and the first vector is kept.
- R4: A request with mode 3 (reserved) changes no state.
- R5: System-management, non-maskable, init and startup are presented whatever `int_enable` is. External and regular interrupts are presented only while `int_enable` is 1.
- R6: A regular vector is presented only when two conditions hold. First, it is above the highest in-service vector, or nothing is in service. Second, its bits 7:4 are strictly greater than `tpr_value` bits 7:4.
- R7: Presentation order is system-management (kind 1), non-maskable (2), init (3), startup (4), external (5), then the highest eligible regular vector (6). Kind 0 means none.
- R8: `ack` retires the presented item. For a regular vector, `ack` clears its pending bit and sets its in-service bit, and the next-highest pending vector becomes the candidate.
- R9: `eoi` clears the highest set in-service bit.
- R10: A `tpr_wr` stores only the low 8 bits of `tpr_data`.
- R11: When `ack` and a new request arrive in the same cycle, the acknowledge is applied first. A request of the kind just retired is therefore latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Delivery mode of the request |
| req_vector | input | 8 | Vector of the request |
| req_level | input | 1 | 1 for a level request, 0 for an edge request |
| int_enable | input | 1 | Core interrupt-enable flag |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_data | input | 32 | Task-priority write data |
| ack | input | 1 | Core takes the presented interrupt |
| eoi | input | 1 | End of interrupt |
| int_pending | output | 1 | An interrupt is presented |
| int_kind | output | 3 | Kind of the presented interrupt |
| int_vector | output | 8 | Vector of the presented interrupt |
| int_level | output | 1 | Trigger bit of the highest pending regular vector |
| isr_any | output | 1 | At least one vector is in service |
| isr_top | output | 8 | Highest in-service vector |
| tpr_value | output | 8 | Current task priority |

## Verification
The bench builds the block with its default parameters: 8-bit vectors and 4-bit priority classes. This gives the full 256-entry bitmaps, so high vectors such as 0x90 and 0x9A can be used. With these widths, equal priority classes and a class above the task priority can both be set up directly at the boundary of the class comparison. Nesting is tested with two vectors in service at once, and the order of `eoi` retirement is checked. The same-cycle case of an acknowledge and a request of the same kind is also covered.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWEST = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXT    = 3'd7
  } dmode_e;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_SMI   = 3'd1,
    SRC_NMI   = 3'd2,
    SRC_INIT  = 3'd3,
    SRC_START = 3'd4,
    SRC_EXT   = 3'd5,
    SRC_REG   = 3'd6
  } src_e;

  // single-entry latches, listed in service order
  localparam int NLAT    = 5;
  localparam int NUNMASK = 4;

  function automatic logic [2:0] latch_mode(input int k);
    case (k)
      0:       return DM_SMI;
      1:       return DM_NMI;
      2:       return DM_INIT;
      3:       return DM_START;
      default: return DM_EXT;
    endcase
  endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W  = 256,
  parameter int IW = 8
) (
  input  logic [W-1:0]  bits_in,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |bits_in;
    for (int i = 0; i < W; i++) begin
      if (bits_in[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic             clr,
  input  logic [VEC_W-1:0] vec_in,
  output logic             pending,
  output logic [VEC_W-1:0] vec
);
  logic             pend_q, pend_d;
  logic [VEC_W-1:0] vec_q;
  logic             load;

  // retire first, then accept only into an empty slot
  always_comb begin
    load   = set && !(pend_q && !clr);
    pend_d = (pend_q && !clr) || load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (load) vec_q <= vec_in;
    end
  end

  assign pending = pend_q;
  assign vec     = vec_q;
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_accept_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_mode,
  input  logic [VEC_W-1:0] req_vector,
  input  logic             req_level,
  input  logic             int_enable,
  input  logic             tpr_wr,
  input  logic [REG_W-1:0] tpr_data,
  input  logic             ack,
  input  logic             eoi,
  output logic             int_pending,
  output logic [2:0]       int_kind,
  output logic [VEC_W-1:0] int_vector,
  output logic             int_level,
  output logic             isr_any,
  output logic [VEC_W-1:0] isr_top,
  output logic [VEC_W-1:0] tpr_value
);
  localparam int NVEC = 1 << VEC_W;

  logic [NVEC-1:0]  irr_q, irr_d, irr_after;
  logic [NVEC-1:0]  trig_q, trig_d;
  logic [NVEC-1:0]  isr_q, isr_d;
  logic [VEC_W-1:0] tpr_q;
  logic             irr_en, isr_en;

  logic [VEC_W-1:0] irr_top;
  logic             irr_any;
  logic             reg_ok;
  logic             req_reg, reg_ack;
  logic             unused_hi;

  logic             lat_pend [NLAT];
  logic [VEC_W-1:0] lat_vec  [NLAT];
  logic             lat_clr  [NLAT];

  src_e             sel_kind;
  logic [VEC_W-1:0] sel_vec;

  assign unused_hi = ^tpr_data[REG_W-1:VEC_W];

  irq_prio_enc #(.W(NVEC), .IW(VEC_W)) u_irr_enc (
    .bits_in(irr_q), .idx(irr_top), .any(irr_any)
  );
  irq_prio_enc #(.W(NVEC), .IW(VEC_W)) u_isr_enc (
    .bits_in(isr_q), .idx(isr_top), .any(isr_any)
  );

  for (genvar g = 0; g < NLAT; g++) begin : g_lat
    localparam logic [2:0] MC = latch_mode(g);
    irq_pend_latch #(.VEC_W(VEC_W)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (req_valid && (req_mode == MC)),
      .clr    (lat_clr[g]),
      .vec_in (req_vector),
      .pending(lat_pend[g]),
      .vec    (lat_vec[g])
    );
  end

  // regular vector eligibility
  always_comb begin
    reg_ok = irr_any
          && (!isr_any || (irr_top > isr_top))
          && (irr_top[VEC_W-1 -: CLS_W] > tpr_q[VEC_W-1 -: CLS_W]);
  end

  // fixed-order arbitration; lower latch index wins
  always_comb begin
    sel_kind = SRC_NONE;
    sel_vec  = '0;
    if (reg_ok && int_enable) begin
      sel_kind = SRC_REG;
      sel_vec  = irr_top;
    end
    for (int i = NLAT - 1; i >= 0; i--) begin
      if (lat_pend[i] && ((i < NUNMASK) || int_enable)) begin
        sel_kind = src_e'(3'(i + 1));
        sel_vec  = lat_vec[i];
      end
    end
    for (int i = 0; i < NLAT; i++) begin
      lat_clr[i] = ack && (sel_kind == src_e'(3'(i + 1)));
    end
  end

  // bitmap next state: retire first, then new request
  always_comb begin
    reg_ack   = ack && (sel_kind == SRC_REG);
    req_reg   = req_valid && ((req_mode == DM_FIXED) || (req_mode == DM_LOWEST));
    irr_after = irr_q & ~(reg_ack ? (NVEC'(1) << irr_top) : '0);
    irr_d     = irr_after | (req_reg ? (NVEC'(1) << req_vector) : '0);
    trig_d    = trig_q;
    if (req_reg && !irr_after[req_vector]) trig_d[req_vector] = req_level;
    isr_d     = (isr_q & ~((eoi && isr_any) ? (NVEC'(1) << isr_top) : '0))
              | (reg_ack ? (NVEC'(1) << irr_top) : '0);
    irr_en    = reg_ack || req_reg;
    isr_en    = reg_ack || eoi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      trig_q <= '0;
      isr_q  <= '0;
      tpr_q  <= '0;
    end else begin
      if (irr_en) begin
        irr_q  <= irr_d;
        trig_q <= trig_d;
      end
      if (isr_en) isr_q <= isr_d;
      if (tpr_wr) tpr_q <= tpr_data[VEC_W-1:0];
    end
  end

  assign int_pending = (sel_kind != SRC_NONE);
  assign int_kind    = sel_kind;
  assign int_vector  = sel_vec;
  assign int_level   = trig_q[irr_top];
  assign tpr_value   = tpr_q;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack,
  input logic             eoi,
  input logic             int_enable,
  input logic             tpr_wr,
  input logic [REG_W-1:0] tpr_data,
  input logic             int_pending,
  input logic [2:0]       int_kind,
  input logic [VEC_W-1:0] int_vector,
  input logic             isr_any,
  input logic [VEC_W-1:0] isr_top,
  input logic [VEC_W-1:0] tpr_value
);
  // R5
  masked_only_unmaskable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_enable && int_pending) |-> (int_kind >= 3'd1 && int_kind <= 3'd4));

  // R6
  reg_above_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_kind == 3'd6) |-> (!isr_any || int_vector > isr_top));

  // R6
  reg_above_task_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_kind == 3'd6) |-> (int_vector[VEC_W-1 -: CLS_W] > tpr_value[VEC_W-1 -: CLS_W]));

  // R8
  ack_enters_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_kind == 3'd6) |=> (isr_any && isr_top == $past(int_vector)));

  // R9
  eoi_lowers_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && isr_any) |=> (!isr_any || isr_top < $past(isr_top)));

  // R10
  tpr_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_wr |=> (tpr_value == $past(tpr_data[VEC_W-1:0])));
endmodule

bind irq_accept irq_accept_chk #(.VEC_W(VEC_W), .CLS_W(CLS_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/tb_irq_accept.sv
module tb_irq_accept;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_level, int_enable, tpr_wr, ack, eoi;
  logic [2:0]  req_mode;
  logic [7:0]  req_vector;
  logic [31:0] tpr_data;
  logic        int_pending, int_level, isr_any;
  logic [2:0]  int_kind;
  logic [7:0]  int_vector, isr_top, tpr_value;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_accept dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_vector(req_vector), .req_level(req_level), .int_enable(int_enable),
    .tpr_wr(tpr_wr), .tpr_data(tpr_data), .ack(ack), .eoi(eoi),
    .int_pending(int_pending), .int_kind(int_kind), .int_vector(int_vector),
    .int_level(int_level), .isr_any(isr_any), .isr_top(isr_top),
    .tpr_value(tpr_value)
  );

  typedef struct packed {
    logic [2:0] mode;
    logic       v;
    logic [7:0] vec;
    logic       lvl;
    logic       a;
    logic       e;
    logic       ien;
    logic       pend;
    logic [2:0] kind;
    logic [7:0] evec;
  } row_t;

  // rows cover R2 R3 R4 R5 R6 R7 R8 R9
  localparam int NROW = 16;
  localparam row_t TBL [NROW] = '{
    '{3'd0, 1'b1, 8'h45, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd6, 8'h45},
    '{3'd0, 1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd6, 8'h45},
    '{3'd4, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2, 8'h02},
    '{3'd2, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 8'h11},
    '{3'd7, 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 8'h11},
    '{3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd2, 8'h02},
    '{3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd5, 8'h77},
    '{3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd6, 8'h45},
    '{3'd3, 1'b1, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd6, 8'h45},
    '{3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'd0, 8'h00},
    '{3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3'd6, 8'h30},
    '{3'd0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00},
    '{3'd5, 1'b1, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 8'h05},
    '{3'd6, 1'b1, 8'h9A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 8'h05},
    '{3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd4, 8'h9A},
    '{3'd0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd6, 8'h30}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] m, input logic [7:0] vec,
                       input logic lvl, input logic a, input logic e);
    @(negedge clk);
    req_valid = v; req_mode = m; req_vector = vec; req_level = lvl; ack = a; eoi = e;
    @(posedge clk);
    #1;
    req_valid = 1'b0; ack = 1'b0; eoi = 1'b0;
  endtask

  task automatic wr_tpr(input logic [31:0] d);
    @(negedge clk);
    tpr_wr = 1'b1; tpr_data = d;
    @(posedge clk);
    #1;
    tpr_wr = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic p, input logic [2:0] k,
                            input logic [7:0] v);
    chk({tag, " pending"}, 32'(int_pending), 32'(p));
    chk({tag, " kind"},    32'(int_kind),    32'(k));
    chk({tag, " vector"},  32'(int_vector),  32'(v));
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_mode = 3'd0; req_vector = 8'h00; req_level = 1'b0;
    int_enable = 1'b1; tpr_wr = 1'b0; tpr_data = 32'h0; ack = 1'b0; eoi = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    expect_out("R1 reset", 1'b0, 3'd0, 8'h00);
    chk("R1 isr_any", 32'(isr_any), 32'd0);
    chk("R1 tpr", 32'(tpr_value), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int r = 0; r < NROW; r++) begin
      int_enable = TBL[r].ien;
      drive(TBL[r].v, TBL[r].mode, TBL[r].vec, TBL[r].lvl, TBL[r].a, TBL[r].e);
      expect_out($sformatf("table R7 row %0d", r), TBL[r].pend, TBL[r].kind, TBL[r].evec);
      if (r == 9) chk("R8 isr_top after ack", 32'(isr_top), 32'h45);
    end

    // R10 task priority keeps low byte and gates by class (R6)
    wr_tpr(32'h0000ABC3);
    chk("R10 tpr low byte", 32'(tpr_value), 32'hC3);
    chk("R6 class below tpr", 32'(int_pending), 32'd0);
    wr_tpr(32'h20);
    expect_out("R6 class above tpr", 1'b1, 3'd6, 8'h30);
    wr_tpr(32'h3F);
    chk("R6 equal class", 32'(int_pending), 32'd0);
    wr_tpr(32'h0);

    // R2 trigger bit only on first arrival
    drive(1'b1, 3'd0, 8'h80, 1'b1, 1'b0, 1'b0);
    expect_out("R2 level vec", 1'b1, 3'd6, 8'h80);
    chk("R2 level bit", 32'(int_level), 32'd1);
    drive(1'b1, 3'd1, 8'h80, 1'b0, 1'b0, 1'b0);
    chk("R2 repeat keeps level", 32'(int_level), 32'd1);
    drive(1'b1, 3'd0, 8'h81, 1'b0, 1'b0, 1'b0);
    expect_out("R2 edge vec", 1'b1, 3'd6, 8'h81);
    chk("R2 edge bit", 32'(int_level), 32'd0);

    // R3 duplicate non-maskable is dropped
    drive(1'b1, 3'd4, 8'h10, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 3'd4, 8'h20, 1'b0, 1'b0, 1'b0);
    expect_out("R3 first vector kept", 1'b1, 3'd2, 8'h10);
    drive(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0);
    expect_out("R3 after ack", 1'b1, 3'd6, 8'h81);

    // R11 acknowledge before same-cycle request
    drive(1'b1, 3'd4, 8'h33, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 3'd4, 8'h44, 1'b0, 1'b1, 1'b0);
    expect_out("R11 relatched", 1'b1, 3'd2, 8'h44);
    drive(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0);
    expect_out("R11 drained", 1'b1, 3'd6, 8'h81);

    // R8 and R9 nesting
    drive(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R8 isr_top 81", 32'(isr_top), 32'h81);
    chk("R6 lower vector blocked", 32'(int_pending), 32'd0);
    drive(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R9 isr empty", 32'(isr_any), 32'd0);
    expect_out("R9 next regular", 1'b1, 3'd6, 8'h80);
    drive(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0);
    drive(1'b1, 3'd0, 8'h90, 1'b0, 1'b0, 1'b0);
    expect_out("R6 higher preempts", 1'b1, 3'd6, 8'h90);
    drive(1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 1'b0);
    chk("R8 nested top", 32'(isr_top), 32'h90);
    drive(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R9 highest retired", 32'(isr_top), 32'h80);
    drive(1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 1'b1);
    chk("R9 all retired", 32'(isr_any), 32'd0);
    expect_out("R8 remaining", 1'b1, 3'd6, 8'h30);

    done = 1'b1;
    finish_run();
  end
endmodule